// File: doc/BRIEF.md
# Mirrored Three-Write Register File With Split Read Sides

This block holds thirty-two 32-bit general-purpose registers in two identical physical copies. An issue stage with two dispatch sides uses it. The load/simple-integer side reads from one copy and the complex-integer side reads from the other. Each side therefore has three read ports of its own, and neither side takes read bandwidth from the other.

There is a single set of three write ports, and every write is broadcast to both copies. Each copy resolves same-cycle conflicts on its own with the same fixed priority, so the two copies stay identical at all times. Reads are combinational. A parameter decides whether a read of a register being written in the same cycle returns the stored value or the incoming one. A comparison output flags any register on which the two copies disagree. The testbench watches this output as a consistency check.

Top module: `gpr_dual_file`

## Requirements
- R1: An active-low asynchronous reset clears every register in both copies to zero. This includes a reset that arrives after registers have been written.
- R2: A value written through any write port can be read from every read port of both sides, starting in the cycle after the rising clock edge that stored it.
- R3: The three write ports can update three different registers in the same cycle, and all three updates take effect.
- R4: When two or more enabled write ports target the same register in one cycle, the port with the highest index (port 2 over port 1 over port 0) supplies the stored value.
- R5: With WRITE_THROUGH = 0, a read of a register that is being written in the same cycle returns the value held before that cycle's clock edge.
- R6: Each read port returns the register selected by its own address. This holds for both sides at the same time, even when the two sides use different addresses.
- R7: `copy_mismatch` stays 0 during operation, because both copies hold identical contents.
- R8: With WRITE_THROUGH = 1, a read of a register being written in the same cycle returns the value that will be stored, with the R4 priority applied.
- R9: A write port whose enable is 0 changes no register, whatever its address and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 3 | Enable for each write port |
| wr_addr | input | 3×5 | Register index for each write port |
| wr_data | input | 3×32 | Write data for each write port |
| ls_rd_addr | input | 3×5 | Register index for each read port on the load/simple side |
| ls_rd_data | output | 3×32 | Read data on the load/simple side |
| cx_rd_addr | input | 3×5 | Register index for each read port on the complex side |
| cx_rd_data | output | 3×32 | Read data on the complex side |
| copy_mismatch | output | 1 | High if any register differs between the two copies |

## Verification
Read data is combinational, so a read result is due in the same cycle its address is applied. The bench drives addresses on the falling edge and samples one time unit later, before the next rising edge. A write result is due one rising edge after the write is presented. The bench therefore drives writes on a falling edge, lets one rising edge pass, clears the enables on the next falling edge, and only then reads back. Same-cycle checks for R5 and R8 are taken while the write enables are still high, before the committing edge. Two instances are compared at that point: one with write-through and one without.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int unsigned GPR_DEPTH  = 32;
    localparam int unsigned GPR_XLEN   = 32;
    localparam int unsigned GPR_WPORTS = 3;
    localparam int unsigned GPR_RPORTS = 3;
    localparam int unsigned GPR_SIDES  = 2;

    // Which copy feeds which dispatch side.
    typedef enum logic {
        SIDE_LS = 1'b0,
        SIDE_CX = 1'b1
    } gpr_side_e;

endpackage

// File: rtl/gpr_wr_resolve.sv
module gpr_wr_resolve #(
    parameter int DEPTH = 32,
    parameter int XLEN  = 32,
    parameter int NWR   = 3,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic [NWR-1:0]                 wr_en,
    input  logic [NWR-1:0][AW-1:0]         wr_addr,
    input  logic [NWR-1:0][XLEN-1:0]       wr_data,
    output logic [DEPTH-1:0]               hit,
    output logic [DEPTH-1:0][XLEN-1:0]     val
);

    // One decoder per register: scan ports upward so the highest index wins.
    for (genvar r = 0; r < DEPTH; r++) begin : g_reg
        logic            h;
        logic [XLEN-1:0] v;

        always_comb begin
            h = 1'b0;
            v = '0;
            for (int p = 0; p < NWR; p++) begin
                if (wr_en[p] && (wr_addr[p] == AW'(r))) begin
                    h = 1'b1;
                    v = wr_data[p];
                end
            end
        end

        assign hit[r] = h;
        assign val[r] = v;
    end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
    parameter int DEPTH         = 32,
    parameter int XLEN          = 32,
    parameter int NWR           = 3,
    parameter int NRD           = 3,
    parameter bit WRITE_THROUGH = 1'b0,
    parameter int AW            = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NWR-1:0]                 wr_en,
    input  logic [NWR-1:0][AW-1:0]         wr_addr,
    input  logic [NWR-1:0][XLEN-1:0]       wr_data,
    input  logic [NRD-1:0][AW-1:0]         rd_addr,
    output logic [NRD-1:0][XLEN-1:0]       rd_data,
    output logic [DEPTH-1:0][XLEN-1:0]     contents
);

    logic [DEPTH-1:0][XLEN-1:0] mem_q;
    logic [DEPTH-1:0]           upd_hit;
    logic [DEPTH-1:0][XLEN-1:0] upd_val;

    // Each copy resolves its own conflicts; identical logic keeps copies equal.
    gpr_wr_resolve #(
        .DEPTH (DEPTH),
        .XLEN  (XLEN),
        .NWR   (NWR),
        .AW    (AW)
    ) u_resolve (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hit     (upd_hit),
        .val     (upd_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            for (int r = 0; r < DEPTH; r++) begin
                if (upd_hit[r]) begin
                    mem_q[r] <= upd_val[r];
                end
            end
        end
    end

    for (genvar q = 0; q < NRD; q++) begin : g_rd
        if (WRITE_THROUGH) begin : g_bypass
            assign rd_data[q] = upd_hit[rd_addr[q]] ? upd_val[rd_addr[q]]
                                                    : mem_q[rd_addr[q]];
        end else begin : g_stored
            assign rd_data[q] = mem_q[rd_addr[q]];
        end
    end

    assign contents = mem_q;

endmodule

// File: rtl/gpr_mirror_cmp.sv
module gpr_mirror_cmp #(
    parameter int DEPTH = 32,
    parameter int XLEN  = 32
) (
    input  logic [DEPTH-1:0][XLEN-1:0] copy_a,
    input  logic [DEPTH-1:0][XLEN-1:0] copy_b,
    output logic                       differ
);

    logic [DEPTH-1:0] diff_bits;

    for (genvar r = 0; r < DEPTH; r++) begin : g_cmp
        assign diff_bits[r] = (copy_a[r] != copy_b[r]);
    end

    assign differ = |diff_bits;

endmodule

// File: rtl/gpr_dual_file.sv
module gpr_dual_file #(
    parameter int DEPTH         = gpr_pkg::GPR_DEPTH,
    parameter int XLEN          = gpr_pkg::GPR_XLEN,
    parameter int NWR           = gpr_pkg::GPR_WPORTS,
    parameter int NRD           = gpr_pkg::GPR_RPORTS,
    parameter bit WRITE_THROUGH = 1'b0,
    parameter int AW            = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NWR-1:0]             wr_en,
    input  logic [NWR-1:0][AW-1:0]     wr_addr,
    input  logic [NWR-1:0][XLEN-1:0]   wr_data,
    input  logic [NRD-1:0][AW-1:0]     ls_rd_addr,
    output logic [NRD-1:0][XLEN-1:0]   ls_rd_data,
    input  logic [NRD-1:0][AW-1:0]     cx_rd_addr,
    output logic [NRD-1:0][XLEN-1:0]   cx_rd_data,
    output logic                       copy_mismatch
);

    localparam int NCOPY = gpr_pkg::GPR_SIDES;
    localparam int LS    = int'(gpr_pkg::SIDE_LS);
    localparam int CX    = int'(gpr_pkg::SIDE_CX);

    logic [NCOPY-1:0][NRD-1:0][AW-1:0]     side_addr;
    logic [NCOPY-1:0][NRD-1:0][XLEN-1:0]   side_data;
    logic [NCOPY-1:0][DEPTH-1:0][XLEN-1:0] copy_contents;

    assign side_addr[LS] = ls_rd_addr;
    assign side_addr[CX] = cx_rd_addr;
    assign ls_rd_data    = side_data[LS];
    assign cx_rd_data    = side_data[CX];

    // Writes fan out to every copy; reads stay on their own side.
    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        gpr_bank #(
            .DEPTH         (DEPTH),
            .XLEN          (XLEN),
            .NWR           (NWR),
            .NRD           (NRD),
            .WRITE_THROUGH (WRITE_THROUGH),
            .AW            (AW)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .rd_addr  (side_addr[c]),
            .rd_data  (side_data[c]),
            .contents (copy_contents[c])
        );
    end

    gpr_mirror_cmp #(
        .DEPTH (DEPTH),
        .XLEN  (XLEN)
    ) u_cmp (
        .copy_a (copy_contents[LS]),
        .copy_b (copy_contents[CX]),
        .differ (copy_mismatch)
    );

endmodule

// File: rtl/gpr_dual_file_chk.sv
module gpr_dual_file_chk #(
    parameter int DEPTH         = 32,
    parameter int XLEN          = 32,
    parameter int NWR           = 3,
    parameter int NRD           = 3,
    parameter bit WRITE_THROUGH = 1'b0,
    parameter int AW            = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NWR-1:0]             wr_en,
    input  logic [NWR-1:0][AW-1:0]     wr_addr,
    input  logic [NWR-1:0][XLEN-1:0]   wr_data,
    input  logic [NRD-1:0][AW-1:0]     ls_rd_addr,
    input  logic [NRD-1:0][XLEN-1:0]   ls_rd_data,
    input  logic [NRD-1:0][AW-1:0]     cx_rd_addr,
    input  logic [NRD-1:0][XLEN-1:0]   cx_rd_data,
    input  logic                       copy_mismatch
);

    logic past_ok;
    logic bypass_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign bypass_now = WRITE_THROUGH && (|wr_en);

    // R7
    copies_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_mismatch);

    for (genvar q = 0; q < NRD; q++) begin : g_side
        // R6
        sides_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ls_rd_addr[q] == cx_rd_addr[q]) |-> (ls_rd_data[q] == cx_rd_data[q]));
    end

    // R2
    top_port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && wr_en[NWR-1]) |=>
        ((ls_rd_addr[0] != $past(wr_addr[NWR-1])) || bypass_now ||
         (ls_rd_data[0] == $past(wr_data[NWR-1]))));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !(|wr_en)) |=>
        ((ls_rd_addr[0] != $past(ls_rd_addr[0])) || bypass_now ||
         (ls_rd_data[0] == $past(ls_rd_data[0]))));

    if (NWR >= 3) begin : g_prio
        // R4
        low_pair_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && wr_en[1] && wr_en[0] && (wr_addr[1] == wr_addr[0]) &&
             !(wr_en[2] && (wr_addr[2] == wr_addr[0]))) |=>
            ((cx_rd_addr[0] != $past(wr_addr[0])) || bypass_now ||
             (cx_rd_data[0] == $past(wr_data[1]))));
    end

endmodule

bind gpr_dual_file gpr_dual_file_chk #(
    .DEPTH         (DEPTH),
    .XLEN          (XLEN),
    .NWR           (NWR),
    .NRD           (NRD),
    .WRITE_THROUGH (WRITE_THROUGH),
    .AW            (AW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .ls_rd_addr    (ls_rd_addr),
    .ls_rd_data    (ls_rd_data),
    .cx_rd_addr    (cx_rd_addr),
    .cx_rd_data    (cx_rd_data),
    .copy_mismatch (copy_mismatch)
);

// File: tb/gpr_dual_file_test.sv
module gpr_dual_file_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam int XLEN  = 32;
    localparam int NWR   = 3;
    localparam int NRD   = 3;
    localparam int AW    = 5;
    localparam int NVEC  = 8;

    // Vector: [38:37] write port, [36:32] register, [31:0] data.
    localparam logic [38:0] VEC [NVEC] = '{
        {2'd0, 5'd0,  32'h0000_A000},
        {2'd1, 5'd31, 32'hFFFF_001F},
        {2'd2, 5'd3,  32'h1234_0003},
        {2'd0, 5'd17, 32'h8000_0011},
        {2'd1, 5'd4,  32'h0BAD_0004},
        {2'd2, 5'd12, 32'hC0DE_000C},
        {2'd1, 5'd20, 32'h5555_0014},
        {2'd0, 5'd1,  32'hAAAA_0001}
    };

    logic                     clk;
    logic                     rst_n;
    logic [NWR-1:0]           wr_en;
    logic [NWR-1:0][AW-1:0]   wr_addr;
    logic [NWR-1:0][XLEN-1:0] wr_data;
    logic [NRD-1:0][AW-1:0]   ls_rd_addr;
    logic [NRD-1:0][AW-1:0]   cx_rd_addr;
    logic [NRD-1:0][XLEN-1:0] ls_data, cx_data, ls_data_wt, cx_data_wt;
    logic                     mism, mism_wt;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    gpr_dual_file #(.WRITE_THROUGH(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ls_rd_addr(ls_rd_addr), .ls_rd_data(ls_data),
        .cx_rd_addr(cx_rd_addr), .cx_rd_data(cx_data), .copy_mismatch(mism)
    );

    gpr_dual_file #(.WRITE_THROUGH(1'b1)) uut_wt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ls_rd_addr(ls_rd_addr), .ls_rd_data(ls_data_wt),
        .cx_rd_addr(cx_rd_addr), .cx_rd_data(cx_data_wt), .copy_mismatch(mism_wt)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Present one write; after the committing edge, drop the enables.
    task automatic commit();
        @(posedge clk);
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic read_both(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        ls_rd_addr[0] = a;
        cx_rd_addr[2] = a;
        #1;
        chk(req, ls_data[0], exp);
        chk(req, cx_data[2], exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n      = 1'b0;
        wr_en      = '0;
        wr_addr    = '0;
        wr_data    = '0;
        ls_rd_addr = '0;
        cx_rd_addr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register reads zero on both sides after reset
        for (int a = 0; a < DEPTH; a++) begin
            ls_rd_addr[a % NRD] = AW'(a);
            cx_rd_addr[a % NRD] = AW'(a);
            #1;
            chk("R1 ls", ls_data[a % NRD], 32'h0);
            chk("R1 cx", cx_data[a % NRD], 32'h0);
        end
        chk("R7 after reset", 32'(mism), 32'h0);

        // R2: vector table, one write port per entry, read back next cycle
        for (int i = 0; i < NVEC; i++) begin
            int p;
            p = int'(VEC[i][38:37]);
            wr_en          = '0;
            wr_en[p]       = 1'b1;
            wr_addr[p]     = VEC[i][36:32];
            wr_data[p]     = VEC[i][31:0];
            commit();
            ls_rd_addr[i % NRD]       = VEC[i][36:32];
            cx_rd_addr[(i + 1) % NRD] = VEC[i][36:32];
            #1;
            chk("R2 ls", ls_data[i % NRD], VEC[i][31:0]);
            chk("R2 cx", cx_data[(i + 1) % NRD], VEC[i][31:0]);
            chk("R7 table", 32'(mism), 32'h0);
        end

        // R3/R6: three distinct writes at once, sides read different orders
        wr_en   = 3'b111;
        wr_addr = {5'd10, 5'd9, 5'd8};
        wr_data = {32'h3333_000A, 32'h2222_0009, 32'h1111_0008};
        commit();
        ls_rd_addr = {5'd10, 5'd9, 5'd8};
        cx_rd_addr = {5'd8, 5'd9, 5'd31};
        #1;
        chk("R3 port0", ls_data[0], 32'h1111_0008);
        chk("R3 port1", ls_data[1], 32'h2222_0009);
        chk("R3 port2", ls_data[2], 32'h3333_000A);
        chk("R6 cx0", cx_data[0], 32'hFFFF_001F);
        chk("R6 cx1", cx_data[1], 32'h2222_0009);
        chk("R6 cx2", cx_data[2], 32'h1111_0008);

        // R4/R8: all three ports on register 5
        wr_en   = 3'b111;
        wr_addr = {5'd5, 5'd5, 5'd5};
        wr_data = {32'hC2C2_0005, 32'hB1B1_0005, 32'hA0A0_0005};
        ls_rd_addr[1] = 5'd5;
        #1;
        chk("R8 triple", ls_data_wt[1], 32'hC2C2_0005);
        chk("R5 triple", ls_data[1], 32'h0);
        commit();
        read_both(5'd5, 32'hC2C2_0005, "R4 triple");

        // R4: ports 0 and 1 collide on register 6, port 2 elsewhere
        wr_en   = 3'b111;
        wr_addr = {5'd7, 5'd6, 5'd6};
        wr_data = {32'h7777_0007, 32'h6161_0006, 32'h6060_0006};
        cx_rd_addr[0] = 5'd6;
        #1;
        chk("R8 pair", cx_data_wt[0], 32'h6161_0006);
        commit();
        read_both(5'd6, 32'h6161_0006, "R4 pair");
        read_both(5'd7, 32'h7777_0007, "R3 pair");

        // R5/R8: same-cycle read of a register holding a table value
        wr_en      = 3'b001;
        wr_addr[0] = 5'd3;
        wr_data[0] = 32'hFEED_0003;
        ls_rd_addr[1] = 5'd3;
        #1;
        chk("R5 old", ls_data[1], 32'h1234_0003);
        chk("R8 new", ls_data_wt[1], 32'hFEED_0003);
        commit();
        #1;
        chk("R5 after", ls_data[1], 32'hFEED_0003);

        // R9: disabled ports carry address and data but change nothing
        wr_en   = 3'b000;
        wr_addr = {5'd8, 5'd8, 5'd8};
        wr_data = {32'hDEAD_DEAD, 32'hDEAD_DEAD, 32'hDEAD_DEAD};
        @(posedge clk);
        @(negedge clk);
        read_both(5'd8, 32'h1111_0008, "R9");
        chk("R7 end", 32'(mism), 32'h0);
        chk("R7 wt", 32'(mism_wt), 32'h0);

        // R1: reset after writes clears the stored values
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_both(5'd31, 32'h0, "R1 re-reset");
        read_both(5'd5, 32'h0, "R1 re-reset");

        finish_run();
    end

endmodule